// File: doc/BRIEF.md
# Quadrature-Phase Time-to-Digital Converter

This block puts a timestamp on each clean logic transition of one asynchronous hit input. The input is sampled four times in every period of the system clock, once on each quarter phase. The 0° and 90° clocks are inputs to the block, and the 180° and 270° instants are their falling edges. The four samples are retimed into the 0° clock domain and joined with the two previous cycles' samples into a twelve-sample stream. A four-sample pattern test on that stream then finds edges and throws away ringing.

Each accepted transition produces a one-cycle valid strobe. With it come a two-bit fine code for the quarter slot in which the new level was first seen, a coarse count from a free-running cycle counter that wraps, and a flag giving the edge direction. Resolution is a quarter of the clock period. At a 360 MHz clock this is roughly 0.69 ns per code. Downstream logic joins the coarse and fine fields into one time value and subtracts such values to measure intervals.

Top module: `tdc_quad_top`

## Requirements
- R1: While rst_n is low, and on the first clk_p0 rising edge after it has been low, ts_valid, ts_fine, ts_rising and ts_coarse are all zero.
- R2: ts_fine gives the quarter slot of the first sample that saw the new level: 0 = clk_p0 rising, 1 = clk_p90 rising, 2 = clk_p0 falling, 3 = clk_p90 falling. Each of these counts within the clk_p0 period that starts at that clk_p0 rising edge.
- R3: The coarse counter advances by one on every clk_p0 rising edge. For two reported edges, the difference of {ts_coarse, ts_fine} equals the number of quarter-phase sample instants between them, modulo 2^(COARSE_W+2).
- R4: An edge first seen in the clk_p0 period that starts at rising edge N is reported with ts_valid high for exactly one cycle, after rising edge N+4 (default SYNC_STAGES of 2).
- R5: ts_rising is 1 for a low-to-high edge and 0 for a high-to-low edge.
- R6: A transition counts as clean only if the two samples before it hold the old level and the two samples from it onward hold the new level. A pulse that lasts one sample produces no report at all.
- R7: If two clean edges fall within the same clk_p0 period, only the earlier one (lower fine code) is reported.
- R8: The coarse counter wraps from all-ones to zero without any indication, and the interval rule of R3 still holds across the wrap.
- R9: Whenever ts_valid is low, ts_fine, ts_rising and ts_coarse are zero.
- R10: Reset clears every pipeline stage. An edge still in flight when reset is asserted is never reported.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_p0 | input | 1 | System clock, 0° phase; its falling edge is the 180° sample instant |
| clk_p90 | input | 1 | Same-frequency clock delayed by a quarter period; its falling edge is the 270° instant |
| rst_n | input | 1 | Synchronous active-low reset |
| hit_in | input | 1 | Asynchronous hit signal to be timestamped |
| ts_coarse | output | COARSE_W | Coarse cycle count of the reported edge |
| ts_fine | output | 2 | Quarter-slot code of the reported edge |
| ts_rising | output | 1 | Edge direction, 1 for rising |
| ts_valid | output | 1 | One-cycle strobe marking a reported edge |

## Verification
The hardest cases to reach from the ports depend on where a transition lands relative to the four sample instants. These are a pulse exactly one sample wide, and two clean edges packed into a single clock period. The bench reaches them by recording the time of a clk_p0 rising edge and counting forward from it in quarter periods. It then changes hit_in two time units before the chosen sample instant, so it knows exactly which quarter slot and which cycle see the change. The same scheduling places a transition so that the reset lands while that transition is still inside the retiming pipeline.

// File: rtl/tdc_pkg.sv
// Package: shared constants, types and the edge pattern function for the
// quadrature-phase time-to-digital converter.
package tdc_pkg;

    localparam int NPHASE  = 4;                 // sample instants per clock
    localparam int FINE_W  = $clog2(NPHASE);    // fine code width
    localparam int WIN     = 4;                 // pattern window in samples
    localparam int STREAM  = 3 * NPHASE;        // old + middle + newest words

    typedef logic [NPHASE-1:0] phase_word_t;    // bit i = sample of slot i

    typedef struct packed {
        logic hit;                              // clean edge at this slot
        logic rising;                           // direction of that edge
    } edge_cls_t;

    // Classify one window; w[0] is the oldest sample, w[2] the candidate.
    function automatic edge_cls_t classify(input logic [WIN-1:0] w);
        edge_cls_t r;
        unique case (w)
            4'b1100: r = '{hit: 1'b1, rising: 1'b1};
            4'b0011: r = '{hit: 1'b1, rising: 1'b0};
            default: r = '{hit: 1'b0, rising: 1'b0};
        endcase
        return r;
    endfunction

endpackage

// File: rtl/tdc_phase_sampler.sv
// Module: first-rank capture of the hit input on four quarter phases.
// Assumes clk_p90 runs at the clk_p0 frequency and lags it by a quarter
// period, and that the four flops sit at equal delay from the input.
module tdc_phase_sampler
    import tdc_pkg::*;
(
    input  logic        clk_p0,
    input  logic        clk_p90,
    input  logic        rst_n,
    input  logic        hit_in,
    output phase_word_t raw_word
);

    logic s_p0, s_p90, s_p180, s_p270;

    // Sample at the 0 degree instant.
    always_ff @(posedge clk_p0) begin
        if (!rst_n) s_p0 <= 1'b0;
        else        s_p0 <= hit_in;
    end

    // Sample at the 90 degree instant.
    always_ff @(posedge clk_p90) begin
        if (!rst_n) s_p90 <= 1'b0;
        else        s_p90 <= hit_in;
    end

    // Sample at the 180 degree instant (inverted 0 degree clock).
    always_ff @(negedge clk_p0) begin
        if (!rst_n) s_p180 <= 1'b0;
        else        s_p180 <= hit_in;
    end

    // Sample at the 270 degree instant (inverted 90 degree clock).
    always_ff @(negedge clk_p90) begin
        if (!rst_n) s_p270 <= 1'b0;
        else        s_p270 <= hit_in;
    end

    assign raw_word = {s_p270, s_p180, s_p90, s_p0};

endmodule

// File: rtl/tdc_retimer.sv
// Module: moves the four phase samples into the clk_p0 domain.
// The first stage is the domain crossing; later stages give settling time.
// Assumes SYNC_STAGES >= 1; every stage adds one cycle of latency.
module tdc_retimer
    import tdc_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic        clk,
    input  logic        rst_n,
    input  phase_word_t raw_word,
    output phase_word_t sync_word
);

    phase_word_t pipe [SYNC_STAGES];

    // Shift the word through the retiming chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < SYNC_STAGES; i++) pipe[i] <= '0;
        end else begin
            pipe[0] <= raw_word;
            for (int i = 1; i < SYNC_STAGES; i++) pipe[i] <= pipe[i-1];
        end
    end

    assign sync_word = pipe[SYNC_STAGES-1];

endmodule

// File: rtl/tdc_edge_encoder.sv
// Module: builds a twelve-sample stream from three consecutive words and
// tests each slot of the middle word with the four-sample pattern.
// The earliest clean slot wins; the result is combinational.
module tdc_edge_encoder
    import tdc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  phase_word_t       new_word,
    output logic              found,
    output logic [FINE_W-1:0] fine,
    output logic              rising
);

    phase_word_t         mid_word, old_word;
    logic [STREAM-1:0]   stream;
    edge_cls_t           cls [NPHASE];

    // Keep the two previous words as history.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mid_word <= '0;
            old_word <= '0;
        end else begin
            mid_word <= new_word;
            old_word <= mid_word;
        end
    end

    assign stream = {new_word, mid_word, old_word};

    for (genvar k = 0; k < NPHASE; k++) begin : g_slot
        // Window: two samples before candidate slot k, the slot, one after.
        assign cls[k] = classify(stream[NPHASE + k - 2 +: WIN]);
    end

    // Pick the earliest clean slot of the middle word.
    always_comb begin
        found  = 1'b0;
        fine   = '0;
        rising = 1'b0;
        for (int k = NPHASE - 1; k >= 0; k--) begin
            if (cls[k].hit) begin
                found  = 1'b1;
                fine   = FINE_W'(k);
                rising = cls[k].rising;
            end
        end
    end

endmodule

// File: rtl/tdc_coarse_counter.sv
// Module: free-running coarse cycle counter that wraps without notice.
module tdc_coarse_counter #(
    parameter int COARSE_W = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    output logic [COARSE_W-1:0] count
);

    // Advance once per clock.
    always_ff @(posedge clk) begin
        if (!rst_n) count <= '0;
        else        count <= count + 1'b1;
    end

endmodule

// File: rtl/tdc_quad_top.sv
// Module: quadrature-phase TDC top. Ties sampler, retimer, encoder and
// counter together and registers one timestamp per clk_p0 cycle.
// Assumes the hit input is slow enough that edges are at least two samples
// apart to be accepted; shorter pulses are treated as ringing.
module tdc_quad_top
    import tdc_pkg::*;
#(
    parameter int COARSE_W    = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic                clk_p0,
    input  logic                clk_p90,
    input  logic                rst_n,
    input  logic                hit_in,
    output logic [COARSE_W-1:0] ts_coarse,
    output logic [FINE_W-1:0]   ts_fine,
    output logic                ts_rising,
    output logic                ts_valid
);

    // Cycles from the edge opening a word's period to the counter value
    // seen when that word's result is registered.
    localparam int STAMP_LAG = SYNC_STAGES + 1;

    phase_word_t         raw_word, sync_word;
    logic                enc_found, enc_rising;
    logic [FINE_W-1:0]   enc_fine;
    logic [COARSE_W-1:0] coarse_cnt;

    tdc_phase_sampler u_sampler (
        .clk_p0   (clk_p0),
        .clk_p90  (clk_p90),
        .rst_n    (rst_n),
        .hit_in   (hit_in),
        .raw_word (raw_word)
    );

    tdc_retimer #(.SYNC_STAGES(SYNC_STAGES)) u_retimer (
        .clk       (clk_p0),
        .rst_n     (rst_n),
        .raw_word  (raw_word),
        .sync_word (sync_word)
    );

    tdc_edge_encoder u_encoder (
        .clk      (clk_p0),
        .rst_n    (rst_n),
        .new_word (sync_word),
        .found    (enc_found),
        .fine     (enc_fine),
        .rising   (enc_rising)
    );

    tdc_coarse_counter #(.COARSE_W(COARSE_W)) u_counter (
        .clk   (clk_p0),
        .rst_n (rst_n),
        .count (coarse_cnt)
    );

    // Register the timestamp; outputs are zero in idle cycles.
    always_ff @(posedge clk_p0) begin
        if (!rst_n || !enc_found) begin
            ts_valid  <= 1'b0;
            ts_fine   <= '0;
            ts_rising <= 1'b0;
            ts_coarse <= '0;
        end else begin
            ts_valid  <= 1'b1;
            ts_fine   <= enc_fine;
            ts_rising <= enc_rising;
            ts_coarse <= coarse_cnt - COARSE_W'(STAMP_LAG);
        end
    end

endmodule

// File: rtl/tdc_quad_chk.sv
// Module: assertion checker bound to tdc_quad_top.
module tdc_quad_chk #(
    parameter int COARSE_W = 16
) (
    input logic                clk,
    input logic                rst_n,
    input logic                ts_valid,
    input logic [1:0]          ts_fine,
    input logic                ts_rising,
    input logic [COARSE_W-1:0] ts_coarse,
    input logic [COARSE_W-1:0] cnt
);

    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        !rst_n |=> (!ts_valid && ts_fine == 2'd0 && !ts_rising && ts_coarse == '0));

    // R9
    idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ts_valid |-> (ts_fine == 2'd0 && !ts_rising && ts_coarse == '0));

    // R3
    cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (cnt == COARSE_W'($past(cnt) + 1'b1)));

    // R8
    cnt_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (&cnt) |=> (cnt == '0));

endmodule

bind tdc_quad_top tdc_quad_chk #(.COARSE_W(COARSE_W)) u_chk (
    .clk       (clk_p0),
    .rst_n     (rst_n),
    .ts_valid  (ts_valid),
    .ts_fine   (ts_fine),
    .ts_rising (ts_rising),
    .ts_coarse (ts_coarse),
    .cnt       (coarse_cnt)
);

// File: tb/tb_tdc_quad_top.sv
// Bench: directed scenarios; hit transitions are placed 2 units before a
// chosen quarter-phase sample instant counted from a recorded clk_p0 edge.
module tb_tdc_quad_top;

    localparam int CW   = 6;
    localparam int TMOD = 1 << (CW + 2);
    localparam int QP   = 5;          // quarter period, clock period 20
    localparam int CAPN = 64;

    logic          clk_p0 = 1'b0, clk_p90 = 1'b0, rst_n = 1'b0, hit_in = 1'b0;
    logic [CW-1:0] ts_coarse;
    logic [1:0]    ts_fine;
    logic          ts_rising, ts_valid;

    int n_tests = 0, n_fail = 0, cyc = 0, cap_n = 0, idle_bad = 0;
    int cap_cyc [CAPN];
    int cap_fine [CAPN];
    int cap_rise [CAPN];
    int cap_coarse [CAPN];
    bit finished = 1'b0;

    tdc_quad_top #(.COARSE_W(CW), .SYNC_STAGES(2)) dut (
        .clk_p0(clk_p0), .clk_p90(clk_p90), .rst_n(rst_n), .hit_in(hit_in),
        .ts_coarse(ts_coarse), .ts_fine(ts_fine), .ts_rising(ts_rising),
        .ts_valid(ts_valid)
    );

    always #10 clk_p0 = ~clk_p0;
    initial begin
        #QP;
        forever #10 clk_p90 = ~clk_p90;
    end

    always @(posedge clk_p0) cyc <= cyc + 1;

    // Log reports away from the active edge.
    always @(negedge clk_p0) begin
        if (rst_n) begin
            if (ts_valid) begin
                cap_cyc[cap_n % CAPN]    = cyc;
                cap_fine[cap_n % CAPN]   = int'(ts_fine);
                cap_rise[cap_n % CAPN]   = int'(ts_rising);
                cap_coarse[cap_n % CAPN] = int'(ts_coarse);
                cap_n++;
            end else if (ts_fine != 0 || ts_rising || ts_coarse != 0) begin
                idle_bad++;
            end
        end
    end

    task automatic check_eq(input string tag, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic mark(output int c0, output longint t0);
        @(posedge clk_p0);
        #1;
        c0 = cyc;
        t0 = longint'($time) - 1;
    endtask

    task automatic drive(input longint t0, input int p, input logic v);
        #(t0 + QP * p - 2 - longint'($time));
        hit_in = v;
    endtask

    task automatic settle(input int n);
        repeat (n) @(posedge clk_p0);
        #2;
    endtask

    function automatic int total(input int idx);
        return (cap_coarse[idx % CAPN] * 4 + cap_fine[idx % CAPN]) % TMOD;
    endfunction

    function automatic int diffmod(input int b, input int a);
        return ((b - a) % TMOD + TMOD) % TMOD;
    endfunction

    // R1: outputs quiet while reset is held.
    task automatic t_reset;
        settle(4);
        check_eq("R1 valid in reset", int'(ts_valid), 0);
        check_eq("R1 fine in reset", int'(ts_fine), 0);
        check_eq("R1 coarse in reset", int'(ts_coarse), 0);
    endtask

    // R2 R4 R5 R3: one pulse with both edges in slot j.
    task automatic t_fine(input int j);
        int c0, base;
        longint t0;
        base = cap_n;
        mark(c0, t0);
        drive(t0, 8 + j, 1'b1);
        drive(t0, 32 + j, 1'b0);
        settle(14);
        check_eq($sformatf("R4 count slot %0d", j), cap_n - base, 2);
        check_eq($sformatf("R2 rise fine slot %0d", j), cap_fine[base % CAPN], j);
        check_eq($sformatf("R5 rise type slot %0d", j), cap_rise[base % CAPN], 1);
        check_eq($sformatf("R4 rise cycle slot %0d", j), cap_cyc[base % CAPN] - c0, 6);
        check_eq($sformatf("R2 fall fine slot %0d", j), cap_fine[(base+1) % CAPN], j);
        check_eq($sformatf("R5 fall type slot %0d", j), cap_rise[(base+1) % CAPN], 0);
        check_eq($sformatf("R4 fall cycle slot %0d", j), cap_cyc[(base+1) % CAPN] - c0, 12);
        check_eq($sformatf("R3 interval slot %0d", j), diffmod(total(base+1), total(base)), 24);
    endtask

    // R3: interval across mixed slots.
    task automatic t_interval;
        int c0, base;
        longint t0;
        base = cap_n;
        mark(c0, t0);
        drive(t0, 9, 1'b1);
        drive(t0, 39, 1'b0);
        settle(16);
        check_eq("R3 count", cap_n - base, 2);
        check_eq("R3 interval", diffmod(total(base+1), total(base)), 30);
        check_eq("R3 fall fine", cap_fine[(base+1) % CAPN], 3);
        check_eq("R4 fall cycle", cap_cyc[(base+1) % CAPN] - c0, 13);
    endtask

    // R8: a pulse longer than the coarse range.
    task automatic t_wrap;
        int c0, base;
        longint t0;
        base = cap_n;
        mark(c0, t0);
        drive(t0, 5, 1'b1);
        drive(t0, 286, 1'b0);
        settle(10);
        check_eq("R8 count", cap_n - base, 2);
        check_eq("R8 interval over wrap", diffmod(total(base+1), total(base)), 281 % TMOD);
        check_eq("R8 fall cycle", cap_cyc[(base+1) % CAPN] - c0, 75);
    endtask

    // R6: single-sample pulses high and low are rejected.
    task automatic t_glitch;
        int c0, base;
        longint t0;
        base = cap_n;
        mark(c0, t0);
        drive(t0, 5, 1'b1);
        drive(t0, 6, 1'b0);
        settle(8);
        check_eq("R6 high glitch dropped", cap_n - base, 0);
        base = cap_n;
        mark(c0, t0);
        drive(t0, 8, 1'b1);
        drive(t0, 20, 1'b0);
        drive(t0, 21, 1'b1);
        drive(t0, 36, 1'b0);
        settle(14);
        check_eq("R6 low glitch count", cap_n - base, 2);
        check_eq("R6 first is rising", cap_rise[base % CAPN], 1);
        check_eq("R6 second is falling", cap_rise[(base+1) % CAPN], 0);
        check_eq("R6 interval", diffmod(total(base+1), total(base)), 28);
    endtask

    // R7: two clean edges in one cycle, earlier one wins.
    task automatic t_same_cycle;
        int c0, base;
        longint t0;
        base = cap_n;
        mark(c0, t0);
        drive(t0, 9, 1'b1);
        drive(t0, 11, 1'b0);
        settle(12);
        check_eq("R7 count", cap_n - base, 1);
        check_eq("R7 fine", cap_fine[base % CAPN], 1);
        check_eq("R7 type", cap_rise[base % CAPN], 1);
    endtask

    // R10: reset while an edge is in flight discards it.
    task automatic t_reset_flight;
        int c0, base;
        longint t0;
        base = cap_n;
        mark(c0, t0);
        drive(t0, 4, 1'b1);
        #(t0 + 30 - longint'($time));
        rst_n = 1'b0;
        drive(t0, 12, 1'b0);
        #(t0 + 90 - longint'($time));
        rst_n = 1'b1;
        settle(12);
        check_eq("R10 in-flight edge dropped", cap_n - base, 0);
        check_eq("R10 valid low after reset", int'(ts_valid), 0);
    endtask

    initial begin
        #(20 * 100000);
        if (!finished) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        t_reset();
        @(negedge clk_p0);
        rst_n = 1'b1;
        settle(4);
        for (int j = 0; j < 4; j++) t_fine(j);
        t_interval();
        t_wrap();
        t_glitch();
        t_same_cycle();
        t_reset_flight();
        check_eq("R9 idle outputs zero", idle_bad, 0);
        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule